// File: doc/BRIEF.md
# Capture/Compare Timer with Selectable Time Base

This block is a 16-bit up-counter with two uses. In compare mode, the counter restarts from zero each time it reaches a programmed limit. Each restart flips a square-wave output and can raise a timer interrupt. In capture mode, a chosen edge on an external pin copies the running count into a capture register and raises a second interrupt. One capture mode also restarts the counter on every capture, which supports pulse-width measurement.

The count advances on ticks. A tick comes from one of seven power-of-two divisions of the system clock, or from rising edges on an external clock pin. Software uses a small register port. Writes take effect on the clock edge. Reads are combinational from the address.

Register map (16-bit data, 3-bit address):
- Address 0 is the control register.
- Address 1 is the compare limit.
- Address 2 is the counter, read-only.
- Address 3 is the capture register, read-only.
- Address 4 holds the interrupt flags.
- Other addresses read as zero.

Top module: `cc_timer16`

## Requirements
- R1: After reset, every register reads zero, `tout_o` is low and both interrupt lines are low.
- R2: The control register holds the following fields:
  - run bit [0];
  - tick source [4:2];
  - mode [6:5];
  - capture polarity [8:7];
  - timer interrupt enable [9].

  Tick source 0 selects rising edges of `ext_clk_i`. Sources 1 to 7 divide the system clock by 2, 4, 8, 32, 128, 512 and 2048. While run is set, the counter advances by one per tick. The divider restarts from zero whenever run is clear, so T clock edges of run produce floor(T/N) ticks.
- R3: In compare mode (mode 00 or 11), a tick that finds the counter equal to the compare limit loads zero instead of incrementing.
- R4: `tout_o` toggles on every compare match. It is driven low while run is clear.
- R5: A compare match sets flag bit 0 only when the interrupt enable is set. `irq_tmr_o` follows flag bit 0.
- R6: In capture modes (01 or 10), a `cap_i` edge selected by the polarity field loads the counter into the capture register. It also sets flag bit 1, which `irq_cap_o` follows. The polarity codes are 00 none, 01 falling, 10 rising and 11 both. No compare clearing happens in capture modes.
- R7: Mode 10 additionally clears the counter on every capture.
- R8: Writing 1 to control bit [1] zeroes the counter in that cycle. This has priority over capture-clear and ticks. The bit is not stored and reads 0.
- R9: Writing 1 to a flag bit clears it. An event in the same cycle wins, and the flag stays set.
- R10: Both pins pass through a two-flop synchronizer. A pin change made before clock edge k takes effect at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| ext_clk_i | input | 1 | External tick source (asynchronous) |
| cap_i | input | 1 | Capture trigger pin (asynchronous) |
| tout_o | output | 1 | Compare toggle output |
| irq_tmr_o | output | 1 | Timer match interrupt request |
| irq_cap_o | output | 1 | Capture interrupt request |

## Verification
The bench builds the block with its default widths: a 16-bit counter and an 11-bit divider. Using the full divider lets every divide ratio up to 2048 be exercised with random run lengths. The bench drives the external tick pin directly, so compare limits, match counts, output parity and capture values are exact. Wrap-around at 16 bits is out of reach within the cycle budget, because limits and run lengths stay small.

// File: rtl/cc_timer16.sv
module cc_timer16 #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        ext_clk_i,
  input  logic        cap_i,
  output logic        tout_o,
  output logic        irq_tmr_o,
  output logic        irq_cap_o
);

  logic             run_q, ie_q;
  logic [2:0]       sel_q;
  logic [1:0]       mode_q, pol_q;
  logic [CNT_W-1:0] cmp_q, cnt_q, cap_q;
  logic [PRE_W-1:0] pre_q, mask;
  logic             tflag_q, cflag_q, tout_q;
  logic [2:0]       ext_sh, cap_sh;

  wire ctrl_wr  = wr_en && addr == 3'd0;
  wire flag_wr  = wr_en && addr == 3'd4;
  wire soft_clr = ctrl_wr && wdata[1];

  wire ext_rise = ext_sh[1] & ~ext_sh[2];
  wire cap_rise = cap_sh[1] & ~cap_sh[2];
  wire cap_fall = ~cap_sh[1] & cap_sh[2];

  wire cmp_mode = mode_q[0] == mode_q[1];
  wire cap_evt  = !cmp_mode && ((pol_q[1] && cap_rise) || (pol_q[0] && cap_fall));

  always_comb begin
    case (sel_q)
      3'd1:    mask = PRE_W'(1);
      3'd2:    mask = PRE_W'(3);
      3'd3:    mask = PRE_W'(7);
      3'd4:    mask = PRE_W'(31);
      3'd5:    mask = PRE_W'(127);
      3'd6:    mask = PRE_W'(511);
      default: mask = PRE_W'(2047);
    endcase
  end

  wire tick  = (sel_q == 3'd0) ? ext_rise : ((pre_q & mask) == mask);
  wire match = run_q && tick && cmp_mode && cnt_q == cmp_q && !soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sh <= '0;
      cap_sh <= '0;
    end else begin
      ext_sh <= {ext_sh[1:0], ext_clk_i};
      cap_sh <= {cap_sh[1:0], cap_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      ie_q   <= 1'b0;
      cmp_q  <= '0;
    end else if (ctrl_wr) begin
      run_q  <= wdata[0];
      sel_q  <= wdata[4:2];
      mode_q <= wdata[6:5];
      pol_q  <= wdata[8:7];
      ie_q   <= wdata[9];
    end else if (wr_en && addr == 3'd1) begin
      cmp_q  <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run_q) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (soft_clr)                   cnt_q <= '0;
    else if (cap_evt && mode_q == 2'b10) cnt_q <= '0;
    else if (match)                      cnt_q <= '0;
    else if (run_q && tick)              cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tflag_q <= 1'b0;
      cflag_q <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      tflag_q <= (match && ie_q) || (tflag_q && !(flag_wr && wdata[0]));
      cflag_q <= cap_evt || (cflag_q && !(flag_wr && wdata[1]));
      if (!run_q)     tout_q <= 1'b0;
      else if (match) tout_q <= ~tout_q;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = {6'd0, ie_q, pol_q, mode_q, sel_q, 1'b0, run_q};
      3'd1:    rdata = 16'(cmp_q);
      3'd2:    rdata = 16'(cnt_q);
      3'd3:    rdata = 16'(cap_q);
      3'd4:    rdata = {14'd0, cflag_q, tflag_q};
      default: rdata = '0;
    endcase
  end

  assign tout_o    = tout_q;
  assign irq_tmr_o = tflag_q;
  assign irq_cap_o = cflag_q;

endmodule

// File: rtl/cc_timer16_chk.sv
module cc_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             tick,
  input logic             match,
  input logic             cap_evt,
  input logic             soft_clr,
  input logic             flag_wr,
  input logic [15:0]      wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap_q,
  input logic             tflag_q,
  input logic             tout_o
);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cap_evt && !soft_clr) |=> cnt_q == $past(cnt_q));

  assert_match_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cnt_q == '0);

  assert_tout_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !tout_o);

  assert_tout_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match && run_q) |=> tout_o != $past(tout_o));

  assert_cap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_q == $past(cnt_q));

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> cnt_q == '0);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && wdata[0] && !match) |=> !tflag_q);

endmodule

bind cc_timer16 cc_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .tick(tick), .match(match),
  .cap_evt(cap_evt), .soft_clr(soft_clr), .flag_wr(flag_wr), .wdata(wdata),
  .cnt_q(cnt_q), .cap_q(cap_q), .tflag_q(tflag_q), .tout_o(tout_o)
);

// File: tb/cc_timer16_tb.sv
module cc_timer16_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0, ext_clk_i = 0, cap_i = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        tout_o, irq_tmr_o, irq_cap_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  cc_timer16 u_dut (.*);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 3'(a); wdata = 16'(d);
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = 3'(a); #1 d = int'(rdata);
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_clk_i = 1; repeat (2) @(posedge clk);
      @(negedge clk) ext_clk_i = 0; repeat (2) @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic set_cap(input bit v);
    @(negedge clk) cap_i = v; repeat (4) @(posedge clk);
  endtask

  function automatic int divof(int s);
    case (s)
      1: return 2;   2: return 4;   3: return 8;   4: return 32;
      5: return 128; 6: return 512; default: return 2048;
    endcase
  endfunction

  function automatic int ctrl(int run, int sel, int mode, int pol, int ie, int clr);
    return run | (clr << 1) | (sel << 2) | (mode << 5) | (pol << 7) | (ie << 9);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, s, t, c, p, ie, m;
    void'($urandom(32'h1c0ffee));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(a, v); check("R1 reg", v, 0); end
    check("R1 tout", tout_o, 0);
    check("R1 irq", irq_tmr_o | irq_cap_o, 0);

    // R2 random prescaler runs
    wr(1, 16'hffff);
    for (int i = 0; i < 16; i++) begin
      s = 1 + ($urandom % 7);
      t = 1 + ($urandom % 3000);
      wr(0, ctrl(1, s, 0, 0, 0, 1));
      repeat (t - 1) @(posedge clk);
      wr(0, ctrl(0, s, 0, 0, 0, 0));
      rd(2, v); check("R2 prescale count", v, t / divof(s));
      check("R2 no toggle", tout_o, 0);
    end
    rd(0, v); check("R8 clear bit reads 0", v & 2, 0);

    // R3 R4 R5 random compare with external ticks
    for (int i = 0; i < 20; i++) begin
      c = $urandom % 7; p = $urandom % 21; ie = $urandom % 2;
      wr(1, c); wr(4, 3);
      m = ($urandom % 2) ? 3 : 0;
      wr(0, ctrl(1, 0, m, 0, ie, 1));
      pulse_ext(p);
      rd(2, v); check("R3 count wraps at limit", v, p % (c + 1));
      check("R4 toggle parity", tout_o, (p / (c + 1)) % 2);
      check("R5 flag vs enable", irq_tmr_o, (ie && p > c) ? 1 : 0);
      wr(0, ctrl(0, 0, 0, 0, ie, 0));
      repeat (2) @(posedge clk);
      check("R4 low when stopped", tout_o, 0);
    end

    // R9 collision and clean clear, R10 timing
    wr(1, 0);
    wr(0, ctrl(1, 0, 0, 0, 1, 1));
    pulse_ext(1);
    check("R5 flag set", irq_tmr_o, 1);
    @(negedge clk) ext_clk_i = 1;
    @(posedge clk); @(posedge clk);
    wr(4, 1);
    #1 check("R9 event wins over clear", irq_tmr_o, 1);
    @(negedge clk) ext_clk_i = 0;
    repeat (4) @(posedge clk);
    wr(4, 1);
    #1 check("R9 clear", irq_tmr_o, 0);

    // R6 R7 capture
    wr(1, 1);
    wr(0, ctrl(1, 0, 1, 2, 0, 1));
    pulse_ext(3);
    rd(2, v); check("R6 no compare clear in capture", v, 3);
    set_cap(1);
    rd(3, v); check("R6 rising capture", v, 3);
    check("R6 capture irq", irq_cap_o, 1);
    wr(4, 2);
    check("R9 capture flag cleared", irq_cap_o, 0);
    pulse_ext(2);
    set_cap(0);
    rd(3, v); check("R6 falling ignored under rising", v, 3);
    check("R6 no irq on ignored edge", irq_cap_o, 0);
    wr(0, ctrl(1, 0, 1, 1, 0, 0));
    set_cap(1);
    rd(3, v); check("R6 rising ignored under falling", v, 3);
    pulse_ext(1);
    set_cap(0);
    rd(3, v); check("R6 falling capture", v, 6);
    wr(0, ctrl(1, 0, 1, 0, 0, 0));
    wr(4, 2);
    set_cap(1); set_cap(0);
    rd(3, v); check("R6 polarity none", v, 6);
    check("R6 polarity none irq", irq_cap_o, 0);
    wr(0, ctrl(1, 0, 2, 3, 0, 0));
    set_cap(1);
    rd(3, v); check("R7 capture value", v, 6);
    rd(2, v); check("R7 counter cleared", v, 0);
    pulse_ext(4);
    set_cap(0);
    rd(3, v); check("R7 width on both edges", v, 4);
    rd(2, v); check("R7 cleared again", v, 0);
    pulse_ext(2);
    wr(0, ctrl(1, 0, 2, 3, 0, 1));
    rd(2, v); check("R8 soft clear", v, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule